// File: doc/BRIEF.md
# Instruction Prefetch Pipeline Tracker

This block runs beside a processor and keeps a model of its three-stage instruction prefetch pipeline, so that a trace tool can tell which instruction words the core is working on. Stage A is a plain input buffer for prefetched words and is never decoded. Stage B holds the word under first decode, which is an opcode or an extension word, and it is also the source of immediate data. Stage C holds the word used for residual opcode decode while the instruction executes. Each stage has a valid flag and a stored word, and all of them are outputs.

Three inputs drive the model. The first is a fetch event, which comes with the fetched word. The second is a flush event, which means the pipe was emptied and the word that comes with it starts refilling the pipe. The third is an active-low advance strobe, which shows that the core has used the stage B word. On an advance, stage B is always invalidated. It is then refilled from stage A if stage A holds a word. A word that was valid in stage B moves on into stage C. All outputs are registered. An event seen at a clock edge shows at the outputs just after that edge.

Top module: `ipipe_tracker`

## Requirements
- R1: While reset is high, at the next clock edge every valid flag and the overflow flag go to 0 and every stage word goes to 0.
- R2: A fetch (fetch_i=1, no flush) while stage A is empty loads word_i into stage A and sets stage A valid after that edge.
- R3: An advance (adv_n_i=0 at the edge, no flush) while stage A is valid copies the stage A word into stage B, sets stage B valid and clears stage A valid.
- R4: An advance while stage A is empty leaves stage B invalid after the edge, whatever stage B held before.
- R5: An advance while stage B is valid copies the stage B word into stage C and sets stage C valid. An advance with stage B empty leaves stage C's flag and word unchanged.
- R6: A flush (flush_i=1) clears the B and C valid flags and loads word_i into stage A as valid. It takes priority over an advance in the same cycle, does not depend on fetch_i, and never sets the overflow flag.
- R7: A fetch and an advance in the same cycle apply the advance first. Stage B takes the old stage A word and stage A then holds the new word as valid.
- R8: A fetch with stage A valid, no advance and no flush leaves stage A unchanged and sets the overflow flag. Once set, the overflow flag stays at 1 until reset.
- R9: A cycle with no fetch, no flush and adv_n_i=1 leaves every flag and word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_i | input | 1 | Prefetch event, qualifies word_i |
| flush_i | input | 1 | Pipe flush event with a refill word |
| word_i | input | WORD_W | Fetched instruction word |
| adv_n_i | input | 1 | Active-low advance strobe, one advance per low cycle |
| a_vld_o | output | 1 | Stage A valid |
| a_word_o | output | WORD_W | Stage A word |
| b_vld_o | output | 1 | Stage B valid |
| b_word_o | output | WORD_W | Stage B word |
| c_vld_o | output | 1 | Stage C valid |
| c_word_o | output | WORD_W | Stage C word |
| ovf_o | output | 1 | Sticky overflow: a fetch found stage A full |

## Verification
Every piece of state is a port, so a wrong flag or word is visible one clock after the edge that corrupted it. A wrong move order would show first as a stale or missing word in stage C, because that word depends on stage B's value before the advance. A missed refill of stage B would show as a wrong flag at the very next compare. A bad overflow decision shows at once and then stays, because the flag is sticky. The random mix of fetches, flushes and advances keeps reaching states with stage A full, with stage B empty and with events in the same cycle, and the directed cases cover each of these on purpose.

// File: rtl/ipipe_pkg.sv
package ipipe_pkg;
  localparam int NSTAGE = 3;
  localparam int STG_A  = 0;
  localparam int STG_B  = 1;
  localparam int STG_C  = 2;

  typedef struct packed {
    logic adv;
    logic flush;
    logic fetch;
  } evt_t;
endpackage

// File: rtl/ipipe_event_dec.sv
module ipipe_event_dec
  import ipipe_pkg::*;
(
  input  evt_t              evt,
  input  logic              a_vld,
  input  logic              b_vld,
  output logic [NSTAGE-1:0] ld,
  output logic [NSTAGE-1:0] clr,
  output logic              ovf_set
);
  logic keep;   // events other than flush
  logic a_free; // stage A can accept a word this cycle

  always_comb begin
    keep   = ~evt.flush;
    a_free = ~a_vld | evt.adv;

    ld[STG_A]  = evt.flush | (evt.fetch & a_free);
    clr[STG_A] = keep & evt.adv;

    ld[STG_B]  = keep & evt.adv & a_vld;
    clr[STG_B] = evt.flush | evt.adv;

    ld[STG_C]  = keep & evt.adv & b_vld;
    clr[STG_C] = evt.flush;

    ovf_set = keep & evt.fetch & ~a_free;
  end
endmodule

// File: rtl/ipipe_stage_reg.sv
module ipipe_stage_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              clr,
  input  logic [WORD_W-1:0] din,
  output logic              vld,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      word <= '0;
    end else if (ld) begin
      vld  <= 1'b1;
      word <= din;
    end else if (clr) begin
      vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/ipipe_tracker.sv
module ipipe_tracker
  import ipipe_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_i,
  input  logic              flush_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              adv_n_i,
  output logic              a_vld_o,
  output logic [WORD_W-1:0] a_word_o,
  output logic              b_vld_o,
  output logic [WORD_W-1:0] b_word_o,
  output logic              c_vld_o,
  output logic [WORD_W-1:0] c_word_o,
  output logic              ovf_o
);
  evt_t              evt;
  logic [NSTAGE-1:0] ld;
  logic [NSTAGE-1:0] clr;
  logic [NSTAGE-1:0] vld;
  logic [WORD_W-1:0] word [NSTAGE];
  logic [WORD_W-1:0] din  [NSTAGE];
  logic              ovf_set;
  logic              ovf_q;

  always_comb begin
    evt.adv   = ~adv_n_i;
    evt.flush = flush_i;
    evt.fetch = fetch_i;
  end

  ipipe_event_dec u_dec (
    .evt     (evt),
    .a_vld   (vld[STG_A]),
    .b_vld   (vld[STG_B]),
    .ld      (ld),
    .clr     (clr),
    .ovf_set (ovf_set)
  );

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    if (s == STG_A) begin : g_src_in
      assign din[s] = word_i;
    end else begin : g_src_prev
      assign din[s] = word[s-1];
    end

    ipipe_stage_reg #(.WORD_W(WORD_W)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .ld   (ld[s]),
      .clr  (clr[s]),
      .din  (din[s]),
      .vld  (vld[s]),
      .word (word[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_q <= 1'b0;
    else if (ovf_set) ovf_q <= 1'b1;
  end

  assign a_vld_o  = vld[STG_A];
  assign a_word_o = word[STG_A];
  assign b_vld_o  = vld[STG_B];
  assign b_word_o = word[STG_B];
  assign c_vld_o  = vld[STG_C];
  assign c_word_o = word[STG_C];
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/ipipe_tracker_chk.sv
module ipipe_tracker_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_i,
  input logic              flush_i,
  input logic [WORD_W-1:0] word_i,
  input logic              adv_n_i,
  input logic              a_vld_o,
  input logic [WORD_W-1:0] a_word_o,
  input logic              b_vld_o,
  input logic [WORD_W-1:0] b_word_o,
  input logic              c_vld_o,
  input logic [WORD_W-1:0] c_word_o,
  input logic              ovf_o
);
  AST_FETCH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!flush_i && fetch_i && !a_vld_o) |=> (a_vld_o && a_word_o == $past(word_i))); // R2
  AST_A_TO_B: assert property (@(posedge clk) disable iff (rst)
    (!flush_i && !adv_n_i && a_vld_o) |=> (b_vld_o && b_word_o == $past(a_word_o))); // R3
  AST_B_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (!flush_i && !adv_n_i && !a_vld_o) |=> !b_vld_o); // R4
  AST_B_TO_C: assert property (@(posedge clk) disable iff (rst)
    (!flush_i && !adv_n_i && b_vld_o) |=> (c_vld_o && c_word_o == $past(b_word_o))); // R5
  AST_FLUSH: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (a_vld_o && !b_vld_o && !c_vld_o && a_word_o == $past(word_i))); // R6
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!flush_i && fetch_i && !adv_n_i) |=> (a_vld_o && a_word_o == $past(word_i))); // R7
  AST_NO_OVERFLOW_DROP: assert property (@(posedge clk) disable iff (rst)
    (!flush_i && fetch_i && adv_n_i && a_vld_o) |=> (ovf_o && $stable(a_word_o))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!flush_i && !fetch_i && adv_n_i) |=>
      ($stable(a_vld_o) && $stable(b_vld_o) && $stable(c_vld_o) &&
       $stable(a_word_o) && $stable(b_word_o) && $stable(c_word_o))); // R9
endmodule

bind ipipe_tracker ipipe_tracker_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .fetch_i(fetch_i), .flush_i(flush_i), .word_i(word_i),
  .adv_n_i(adv_n_i), .a_vld_o(a_vld_o), .a_word_o(a_word_o), .b_vld_o(b_vld_o),
  .b_word_o(b_word_o), .c_vld_o(c_vld_o), .c_word_o(c_word_o), .ovf_o(ovf_o)
);

// File: tb/ipipe_tracker_tb.sv
module ipipe_tracker_tb;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst, fetch_i, flush_i, adv_n_i;
  logic [W-1:0] word_i;
  logic a_vld_o, b_vld_o, c_vld_o, ovf_o;
  logic [W-1:0] a_word_o, b_word_o, c_word_o;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic m_av, m_bv, m_cv, m_ovf;
  logic [W-1:0] m_aw, m_bw, m_cw;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipipe_tracker #(.WORD_W(W)) u_dut (
    .clk(clk), .rst(rst), .fetch_i(fetch_i), .flush_i(flush_i), .word_i(word_i),
    .adv_n_i(adv_n_i), .a_vld_o(a_vld_o), .a_word_o(a_word_o), .b_vld_o(b_vld_o),
    .b_word_o(b_word_o), .c_vld_o(c_vld_o), .c_word_o(c_word_o), .ovf_o(ovf_o)
  );

  function automatic string tag_of(logic fe, logic fl, logic adv, logic av);
    if (fl)              return "R6";
    if (fe && adv)       return "R7";
    if (fe && av)        return "R8";
    if (fe)              return "R2";
    if (adv && av)       return "R3";
    if (adv)             return "R4";
    return "R9";
  endfunction

  task automatic model_step(logic fe, logic fl, logic [W-1:0] w, logic adv);
    if (fl) begin
      m_av = 1; m_aw = w; m_bv = 0; m_cv = 0;
    end else begin
      if (adv) begin
        if (m_bv) begin m_cv = 1; m_cw = m_bw; end // R5
        m_bv = m_av;
        if (m_av) m_bw = m_aw;
        m_av = 0;
      end
      if (fe) begin
        if (m_av) m_ovf = 1;
        else begin m_av = 1; m_aw = w; end
      end
    end
  endtask

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag, "a_vld", W'(a_vld_o), W'(m_av));
    cmp(tag, "b_vld", W'(b_vld_o), W'(m_bv));
    cmp(tag, "c_vld", W'(c_vld_o), W'(m_cv));
    cmp(tag, "ovf",   W'(ovf_o),   W'(m_ovf));
    if (m_av) cmp(tag, "a_word", a_word_o, m_aw);
    if (m_bv) cmp(tag, "b_word", b_word_o, m_bw);
    cmp(tag, "c_word", c_word_o, m_cw);
  endtask

  task automatic apply(logic fe, logic fl, logic [W-1:0] w, logic adv, string tag = "");
    string t;
    t = (tag != "") ? tag : tag_of(fe, fl, adv, m_av);
    fetch_i = fe; flush_i = fl; word_i = w; adv_n_i = ~adv;
    @(posedge clk);
    model_step(fe, fl, w, adv);
    @(negedge clk);
    check_all(t);
  endtask

  task automatic do_reset();
    rst = 1; fetch_i = 0; flush_i = 0; adv_n_i = 1; word_i = '0;
    @(posedge clk); @(posedge clk);
    m_av = 0; m_bv = 0; m_cv = 0; m_ovf = 0; m_aw = '0; m_bw = '0; m_cw = '0;
    @(negedge clk);
    check_all("R1");
    cmp("R1", "a_word", a_word_o, '0);
    cmp("R1", "b_word", b_word_o, '0);
    rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    do_reset();

    // directed corner cases
    apply(1, 0, 16'h1111, 0, "R2");   // fetch into empty A
    apply(0, 0, 16'h0000, 1, "R3");   // A->B, A empty
    apply(0, 0, 16'h0000, 1, "R4");   // A empty: B invalid, B->C (R5)
    apply(0, 0, 16'h0000, 1, "R5");   // B empty: C holds
    apply(1, 0, 16'h2222, 0, "R2");
    apply(1, 0, 16'h3333, 0, "R8");   // A full: drop, overflow
    apply(0, 0, 16'h0000, 0, "R8");   // overflow stays
    apply(1, 0, 16'h4444, 1, "R7");   // advance then load
    apply(0, 0, 16'h5555, 0, "R9");   // idle
    apply(1, 1, 16'h6666, 1, "R6");   // flush beats advance
    apply(0, 1, 16'h7777, 0, "R6");   // flush with A full, no fetch
    do_reset();
    apply(1, 0, 16'h0A0A, 0, "R2");
    apply(1, 1, 16'h0B0B, 0, "R6");   // flush with A full: no overflow

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic fe, fl, adv;
      r   = int'($urandom_range(0, 99));
      fl  = (r < 6);
      fe  = ($urandom_range(0, 99) < 55);
      adv = ($urandom_range(0, 99) < 45);
      apply(fe, fl, W'($urandom), adv);
      if (i == 1500) do_reset();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule